// File: doc/BRIEF.md
# Queue Pair Doorbell Tracker

This block keeps the ring indices of one submission queue and its paired completion queue inside a storage controller. The host moves the submission tail and the completion head by register writes to two doorbell addresses. The controller moves the other two indices: it takes entries from the submission ring and posts entries into the completion ring. Each of these two flows has a valid/ready handshake.

For each ring the block reports the occupancy and whether the ring is empty or full. It also gives the index and byte address of the next slot to fetch from or to post into. One slot of each ring is always left unused, so a full ring is never confused with an empty one, and a ring needs at least two entries.

A doorbell write that names a slot outside the ring is dropped. So is a write that would move the host's index backwards over entries the controller has not handled yet. Either case raises a one-cycle error pulse. Both ring sizes are configuration pins given as zero-based values; they and the base addresses must stay stable while out of reset.

Back-pressure rules:
- On the fetch side, `sq_fetch_valid` is high whenever the submission ring holds at least one entry. The head advances only in a cycle where valid and `sq_fetch_ready` are both high.
- On the post side, `cq_post_ready` is low while the completion ring is full. A request held in that state is stalled and moves nothing until the host frees a slot.

Top module: `qdb_tracker`

## Requirements
- R1: After reset all four indices are 0. Both rings report count 0, empty 1 and full 0. `sq_fetch_valid` is 0, `cq_post_ready` is 1 and `db_err` is 0.
- R2: A write to address DB_BASE + ((2*QID) << STRIDE_SHIFT) loads the submission tail. With defaults (DB_BASE=0x1000, QID=1, STRIDE_SHIFT=2) this is 0x1008. The next stride, 0x100C by default, loads the completion head. A write to any other address changes nothing and raises no error.
- R3: A ring's count is (tail − head) mod N, where N is the zero-based size value plus one. Empty means count 0. Full means count equals N − 1.
- R4: `sq_fetch_valid` is high exactly when the submission ring is not empty. Each cycle with valid and ready both high advances the head by one, wrapping from the zero-based size value to 0. With ready high on an empty ring, the head stays where it is.
- R5: `cq_post_ready` is high exactly when the completion ring is not full. Each cycle with `cq_post_valid` and ready both high advances the tail by one and wraps. A post request while the ring is full leaves the tail unchanged.
- R6: A doorbell write is dropped, and raises `db_err`, if its data exceeds the zero-based size value. This includes any set bit above bit 15 of the write data.
- R7: A submission-tail write that would lower the submission occupancy is dropped and raises `db_err`. So is a completion-head write that would raise the completion occupancy. Writes that leave the occupancy unchanged are accepted.
- R8: Slot addresses are base + (index << entry shift). The submission slot is 64 bytes by default and the completion slot 16 bytes.
- R9: `db_err` is registered. It is high for exactly the cycle after each rejected write and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sq_last | input | 16 | Submission ring size minus one (at least 1) |
| cfg_cq_last | input | 16 | Completion ring size minus one (at least 1) |
| cfg_sq_base | input | 64 | Byte address of submission slot 0 |
| cfg_cq_base | input | 64 | Byte address of completion slot 0 |
| db_wr_en | input | 1 | Register write strobe |
| db_addr | input | 16 | Register write address |
| db_wdata | input | 32 | Register write data |
| db_err | output | 1 | Rejected doorbell write pulse |
| sq_fetch_valid | output | 1 | Submission entry available |
| sq_fetch_ready | input | 1 | Controller takes the entry |
| sq_fetch_idx | output | 16 | Submission head index |
| sq_fetch_addr | output | 64 | Byte address of the submission head slot |
| sq_count | output | 16 | Submission occupancy |
| sq_empty | output | 1 | Submission ring empty |
| sq_full | output | 1 | Submission ring full |
| cq_post_valid | input | 1 | Controller requests to post a completion |
| cq_post_ready | output | 1 | Completion slot free |
| cq_post_idx | output | 16 | Completion tail index |
| cq_post_addr | output | 64 | Byte address of the completion tail slot |
| cq_count | output | 16 | Completion occupancy |
| cq_empty | output | 1 | Completion ring empty |
| cq_full | output | 1 | Completion ring full |

## Verification
The submission ring is tried with several patterns:
- A plain advance of the tail followed by partial fetches, which shows the count arithmetic and the address scaling.
- A tail write that lands below the head, which separates correct modular distance from a plain subtraction.
- A fill to one-short-of-size, which shows that the full flag is set by the unused-slot rule rather than at N.
- Fetch requests held on an empty ring, which show that the handshake guards the head.

The completion ring is filled until a post is refused. The host then frees slots in steps, which exposes the stall and the wrap of the tail. Doorbell data is tried in four forms: out of range, with upper bits set, overtaking, and equal to the present index. These separate the range check, the direction check and the accept path. A same-cycle tail write plus fetch shows that the two updates combine.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int unsigned IDX_W = 16;

  typedef logic [IDX_W-1:0] qidx_t;

  // Advance an index by one, returning to zero after the last slot.
  function automatic qidx_t ring_next(qidx_t idx, qidx_t last);
    return (idx == last) ? '0 : idx + 1'b1;
  endfunction

  // Number of slots from trail up to lead on a ring of last+1 slots.
  function automatic qidx_t ring_dist(qidx_t lead, qidx_t trail, qidx_t last);
    logic [IDX_W:0] d;
    if (lead >= trail)
      d = {1'b0, lead} - {1'b0, trail};
    else
      d = {1'b0, lead} + {1'b0, last} + {{IDX_W{1'b0}}, 1'b1} - {1'b0, trail};
    return d[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/qdb_ring_ptr.sv
module qdb_ring_ptr
  import qdb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  qidx_t last,
  input  logic  step,
  input  logic  load,
  input  qidx_t load_val,
  output qidx_t idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (load)
      idx <= load_val;
    else if (step)
      idx <= ring_next(idx, last);
  end
endmodule

// File: rtl/qdb_ring_status.sv
module qdb_ring_status
  import qdb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned ENTRY_SHIFT = 6
) (
  input  qidx_t             head,
  input  qidx_t             tail,
  input  qidx_t             last,
  input  logic [ADDR_W-1:0] base,
  input  qidx_t             slot,
  output qidx_t             count,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] slot_addr
);
  always_comb begin
    count     = ring_dist(tail, head, last);
    empty     = (count == '0);
    full      = (count == last);
    slot_addr = base + (ADDR_W'(slot) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/qdb_db_decode.sv
module qdb_db_decode
  import qdb_pkg::*;
#(
  parameter int unsigned RA_W         = 16,
  parameter int unsigned DW           = 32,
  parameter int unsigned DB_BASE      = 'h1000,
  parameter int unsigned QID          = 1,
  parameter int unsigned STRIDE_SHIFT = 2
) (
  input  logic            wr_en,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  qidx_t           sq_head,
  input  qidx_t           sq_tail,
  input  qidx_t           sq_last,
  input  qidx_t           cq_head,
  input  qidx_t           cq_tail,
  input  qidx_t           cq_last,
  output logic            sq_tail_load,
  output logic            cq_head_load,
  output qidx_t           load_val,
  output logic            err
);
  localparam int unsigned SQ_OFF = DB_BASE + ((2 * QID) << STRIDE_SHIFT);
  localparam int unsigned CQ_OFF = SQ_OFF + (1 << STRIDE_SHIFT);
  localparam logic [RA_W-1:0] SQ_ADDR = RA_W'(SQ_OFF);
  localparam logic [RA_W-1:0] CQ_ADDR = RA_W'(CQ_OFF);

  logic  hit_sq, hit_cq, upper_zero;
  logic  sq_ok, cq_ok;
  qidx_t sq_old, sq_new, cq_old, cq_new;

  always_comb begin
    hit_sq     = wr_en && (addr == SQ_ADDR);
    hit_cq     = wr_en && (addr == CQ_ADDR);
    load_val   = wdata[IDX_W-1:0];
    upper_zero = (wdata[DW-1:IDX_W] == '0);

    // Submission tail may only grow the occupancy (or keep it).
    sq_old = ring_dist(sq_tail, sq_head, sq_last);
    sq_new = ring_dist(load_val, sq_head, sq_last);
    sq_ok  = upper_zero && (load_val <= sq_last) && (sq_new >= sq_old);

    // Completion head may only shrink the occupancy (or keep it).
    cq_old = ring_dist(cq_tail, cq_head, cq_last);
    cq_new = ring_dist(cq_tail, load_val, cq_last);
    cq_ok  = upper_zero && (load_val <= cq_last) && (cq_new <= cq_old);

    sq_tail_load = hit_sq && sq_ok;
    cq_head_load = hit_cq && cq_ok;
    err          = (hit_sq && !sq_ok) || (hit_cq && !cq_ok);
  end
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
  import qdb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned RA_W         = 16,
  parameter int unsigned DW           = 32,
  parameter int unsigned DB_BASE      = 'h1000,
  parameter int unsigned QID          = 1,
  parameter int unsigned STRIDE_SHIFT = 2,
  parameter int unsigned SQ_SHIFT     = 6,
  parameter int unsigned CQ_SHIFT     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cfg_sq_last,
  input  logic [IDX_W-1:0]  cfg_cq_last,
  input  logic [ADDR_W-1:0] cfg_sq_base,
  input  logic [ADDR_W-1:0] cfg_cq_base,
  input  logic              db_wr_en,
  input  logic [RA_W-1:0]   db_addr,
  input  logic [DW-1:0]     db_wdata,
  output logic              db_err,
  output logic              sq_fetch_valid,
  input  logic              sq_fetch_ready,
  output logic [IDX_W-1:0]  sq_fetch_idx,
  output logic [ADDR_W-1:0] sq_fetch_addr,
  output logic [IDX_W-1:0]  sq_count,
  output logic              sq_empty,
  output logic              sq_full,
  input  logic              cq_post_valid,
  output logic              cq_post_ready,
  output logic [IDX_W-1:0]  cq_post_idx,
  output logic [ADDR_W-1:0] cq_post_addr,
  output logic [IDX_W-1:0]  cq_count,
  output logic              cq_empty,
  output logic              cq_full
);
  qidx_t sq_head, sq_tail, cq_head, cq_tail, db_val;
  logic  sq_tail_load, cq_head_load, err_now;
  logic  sq_take, cq_put;

  qdb_db_decode #(
    .RA_W(RA_W), .DW(DW), .DB_BASE(DB_BASE), .QID(QID), .STRIDE_SHIFT(STRIDE_SHIFT)
  ) u_dec (
    .wr_en(db_wr_en), .addr(db_addr), .wdata(db_wdata),
    .sq_head(sq_head), .sq_tail(sq_tail), .sq_last(cfg_sq_last),
    .cq_head(cq_head), .cq_tail(cq_tail), .cq_last(cfg_cq_last),
    .sq_tail_load(sq_tail_load), .cq_head_load(cq_head_load),
    .load_val(db_val), .err(err_now)
  );

  assign sq_take = sq_fetch_valid && sq_fetch_ready;
  assign cq_put  = cq_post_valid && cq_post_ready;

  qdb_ring_ptr u_sq_head (
    .clk(clk), .rst_n(rst_n), .last(cfg_sq_last),
    .step(sq_take), .load(1'b0), .load_val('0), .idx(sq_head)
  );
  qdb_ring_ptr u_sq_tail (
    .clk(clk), .rst_n(rst_n), .last(cfg_sq_last),
    .step(1'b0), .load(sq_tail_load), .load_val(db_val), .idx(sq_tail)
  );
  qdb_ring_ptr u_cq_head (
    .clk(clk), .rst_n(rst_n), .last(cfg_cq_last),
    .step(1'b0), .load(cq_head_load), .load_val(db_val), .idx(cq_head)
  );
  qdb_ring_ptr u_cq_tail (
    .clk(clk), .rst_n(rst_n), .last(cfg_cq_last),
    .step(cq_put), .load(1'b0), .load_val('0), .idx(cq_tail)
  );

  qdb_ring_status #(.ADDR_W(ADDR_W), .ENTRY_SHIFT(SQ_SHIFT)) u_sq_stat (
    .head(sq_head), .tail(sq_tail), .last(cfg_sq_last), .base(cfg_sq_base),
    .slot(sq_head), .count(sq_count), .empty(sq_empty), .full(sq_full),
    .slot_addr(sq_fetch_addr)
  );
  qdb_ring_status #(.ADDR_W(ADDR_W), .ENTRY_SHIFT(CQ_SHIFT)) u_cq_stat (
    .head(cq_head), .tail(cq_tail), .last(cfg_cq_last), .base(cfg_cq_base),
    .slot(cq_tail), .count(cq_count), .empty(cq_empty), .full(cq_full),
    .slot_addr(cq_post_addr)
  );

  assign sq_fetch_valid = !sq_empty;
  assign cq_post_ready  = !cq_full;
  assign sq_fetch_idx   = sq_head;
  assign cq_post_idx    = cq_tail;

  always_ff @(posedge clk) begin
    if (!rst_n) db_err <= 1'b0;
    else        db_err <= err_now;
  end
endmodule

// File: rtl/qdb_tracker_chk.sv
module qdb_tracker_chk
  import qdb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_sq_last,
  input logic        db_wr_en,
  input logic        db_err,
  input logic        sq_fetch_valid,
  input logic        sq_fetch_ready,
  input logic [15:0] sq_fetch_idx,
  input logic [15:0] sq_count,
  input logic        sq_empty,
  input logic        sq_full,
  input logic        cq_post_valid,
  input logic        cq_post_ready,
  input logic [15:0] cq_post_idx
);
  // R3: occupancy never reaches the ring size
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sq_count <= cfg_sq_last);

  // R3: empty and full never together on a ring of two or more slots
  a_r3_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_empty && sq_full));

  // R4: no fetch offered from an empty ring
  a_r4_no_fetch_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sq_empty |-> !sq_fetch_valid);

  // R4: a fetch handshake steps the head by one with wrap
  a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_fetch_valid && sq_fetch_ready) |=>
      sq_fetch_idx == (($past(sq_fetch_idx) == $past(cfg_sq_last)) ? 16'd0 : $past(sq_fetch_idx) + 16'd1));

  // R5: a stalled post leaves the tail in place
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_post_valid && !cq_post_ready) |=> $stable(cq_post_idx));

  // R9: an error pulse follows a write
  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_err) |-> $past(db_wr_en));
endmodule

bind qdb_tracker qdb_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sq_last(cfg_sq_last), .db_wr_en(db_wr_en),
  .db_err(db_err), .sq_fetch_valid(sq_fetch_valid), .sq_fetch_ready(sq_fetch_ready),
  .sq_fetch_idx(sq_fetch_idx), .sq_count(sq_count), .sq_empty(sq_empty),
  .sq_full(sq_full), .cq_post_valid(cq_post_valid), .cq_post_ready(cq_post_ready),
  .cq_post_idx(cq_post_idx)
);

// File: tb/sim_qdb_tracker.sv
module sim_qdb_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_sq_last = 16'd7;
  logic [15:0] cfg_cq_last = 16'd3;
  logic [63:0] cfg_sq_base = 64'h1000_0000;
  logic [63:0] cfg_cq_base = 64'h2000_0000;
  logic        db_wr_en = 1'b0;
  logic [15:0] db_addr = '0;
  logic [31:0] db_wdata = '0;
  logic        db_err, sq_fetch_valid, sq_empty, sq_full;
  logic        sq_fetch_ready = 1'b0;
  logic [15:0] sq_fetch_idx, sq_count, cq_post_idx, cq_count;
  logic [63:0] sq_fetch_addr, cq_post_addr;
  logic        cq_post_valid = 1'b0;
  logic        cq_post_ready, cq_empty, cq_full;

  localparam logic [15:0] SQ_DB = 16'h1008;
  localparam logic [15:0] CQ_DB = 16'h100C;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  qdb_tracker u0 (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic db_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    db_wr_en = 1'b1; db_addr = a; db_wdata = d;
    @(negedge clk);
    db_wr_en = 1'b0;
  endtask

  task automatic fetch_cycles(int n);
    @(negedge clk);
    sq_fetch_ready = 1'b1;
    repeat (n) @(negedge clk);
    sq_fetch_ready = 1'b0;
  endtask

  task automatic post_cycles(int n);
    @(negedge clk);
    cq_post_valid = 1'b1;
    repeat (n) @(negedge clk);
    cq_post_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "sq_count", sq_count, 0);
    chk("R1", "sq_empty", sq_empty, 1);
    chk("R1", "sq_full", sq_full, 0);
    chk("R1", "sq_fetch_valid", sq_fetch_valid, 0);
    chk("R1", "cq_post_ready", cq_post_ready, 1);
    chk("R1", "cq_empty", cq_empty, 1);
    chk("R1", "db_err", db_err, 0);
  endtask

  task automatic t_sq_basic;
    db_write(SQ_DB, 5);
    chk("R2", "no err on good tail", db_err, 0);
    chk("R3", "sq_count after tail=5", sq_count, 5);
    chk("R4", "fetch_valid", sq_fetch_valid, 1);
    chk("R8", "sq addr slot0", sq_fetch_addr, 64'h1000_0000);
    fetch_cycles(3);
    chk("R4", "head after 3 fetches", sq_fetch_idx, 3);
    chk("R3", "count after fetch", sq_count, 2);
    chk("R8", "sq addr slot3", sq_fetch_addr, 64'h1000_00C0);
  endtask

  task automatic t_sq_wrap;
    db_write(SQ_DB, 1);
    chk("R3", "count with tail below head", sq_count, 6);
    chk("R7", "wrap tail accepted", db_err, 0);
    fetch_cycles(5);
    chk("R4", "head wraps to 0", sq_fetch_idx, 0);
    chk("R3", "count after wrap", sq_count, 1);
  endtask

  task automatic t_sq_full_and_bad;
    db_write(SQ_DB, 7);
    chk("R3", "full count", sq_count, 7);
    chk("R3", "sq_full", sq_full, 1);
    db_write(SQ_DB, 8);
    chk("R6", "err on 8", db_err, 1);
    chk("R6", "count kept", sq_count, 7);
    @(negedge clk);
    chk("R9", "err one cycle", db_err, 0);
    db_write(SQ_DB, 32'h0001_0003);
    chk("R6", "err on upper bits", db_err, 1);
    chk("R6", "count kept upper", sq_count, 7);
    db_write(SQ_DB, 3);
    chk("R7", "err on retreat", db_err, 1);
    chk("R7", "count kept retreat", sq_count, 7);
    db_write(SQ_DB, 7);
    chk("R7", "same value accepted", db_err, 0);
  endtask

  task automatic t_sq_drain;
    fetch_cycles(9);
    chk("R4", "head stops on empty", sq_fetch_idx, 7);
    chk("R4", "empty", sq_empty, 1);
    chk("R4", "valid low on empty", sq_fetch_valid, 0);
  endtask

  task automatic t_cq;
    post_cycles(5);
    chk("R5", "tail stalls at 3", cq_post_idx, 3);
    chk("R5", "ready low when full", cq_post_ready, 0);
    chk("R3", "cq_full", cq_full, 1);
    chk("R8", "cq addr slot3", cq_post_addr, 64'h2000_0030);
    db_write(CQ_DB, 2);
    chk("R2", "cq head accepted", db_err, 0);
    chk("R3", "cq count 1", cq_count, 1);
    chk("R5", "ready again", cq_post_ready, 1);
    db_write(CQ_DB, 0);
    chk("R7", "cq head overtake err", db_err, 1);
    chk("R7", "cq count kept", cq_count, 1);
    db_write(CQ_DB, 4);
    chk("R6", "cq range err", db_err, 1);
    db_write(CQ_DB, 3);
    chk("R3", "cq empty", cq_empty, 1);
    post_cycles(2);
    chk("R5", "cq tail wraps", cq_post_idx, 1);
    chk("R3", "cq count after wrap", cq_count, 2);
  endtask

  task automatic t_other_addr;
    db_write(16'h1000, 2);
    chk("R2", "foreign addr no err", db_err, 0);
    chk("R2", "sq untouched", sq_count, 0);
    chk("R2", "cq untouched", cq_count, 2);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    db_wr_en = 1'b1; db_addr = SQ_DB; db_wdata = 2;
    sq_fetch_ready = 1'b1;
    @(negedge clk);
    db_wr_en = 1'b0;
    chk("R4", "fetch ignored while empty at edge", sq_fetch_idx, 7);
    chk("R3", "count after write", sq_count, 3);
    @(negedge clk);
    sq_fetch_ready = 1'b0;
    chk("R4", "head wraps on fetch", sq_fetch_idx, 0);
    chk("R3", "count after fetch", sq_count, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sq_basic();
    t_sq_wrap();
    t_sq_full_and_bad();
    t_sq_drain();
    t_cq();
    t_other_addr();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule